// File: doc/BRIEF.md
# Serial ADC Result Reader

This block is a serial-bus master that fetches one 10-bit conversion result each time it is asked, from a successive-approximation converter with a three-wire serial port. It runs on the system clock and makes the serial clock by dividing it by a programmable half-period. The converter changes its data line on falling serial-clock edges, so the reader always captures on rising edges. This works whether the clock idles low or idles high.

A request is a valid/ready handshake. The reader pulls chip select low and sends one of three frame shapes:
- a minimal 14-pulse frame;
- two 8-pulse byte transfers (16 pulses);
- an 11-pulse fast frame that stops once the eighth result bit has been captured.

From the captured bits it rebuilds the result. It drops the two undefined leading bits and the echoed least-significant-first tail. It checks that the null bit was low. The result then leaves on a valid/ready stream. The reader holds the result, unchanged, for as long as the consumer keeps ready low. Only after the result has been taken and chip select has stayed high for one full serial period does the reader accept the next request. A separate status pin reports when the current divider setting is too slow for the converter's hold time or too fast for its maximum clock.

Top module: `adc_spi_reader`

## Requirements
- R1: While reset is asserted, `cs_n` is 1 and `res_valid` and `req_ready` are 0. After reset is released, `cs_n` stays high, and `req_ready` rises exactly 2·2^DIV_W clock cycles later. This is one serial period at the largest divider.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From that edge, `cs_n` is 0, `busy` is 1 and `req_ready` is 0. `req_ready` stays 0 until the post-frame gap (R9) has ended. Whenever `req_ready` is 1, `cs_n` is 1.
- R3: One serial half-period is H = `cfg_div`+1 clock cycles. The number of serial-clock pulses N depends on `cfg_mode`: 14 for 2'b00 and 2'b11, 16 for 2'b01, and 11 for 2'b10. `sclk` idles at `cfg_cpol` (0 = idle low, 1 = idle high). It returns to that level at the end of the frame and does not move while `cs_n` is high outside idle. `miso` is captured on each 0→1 transition of `sclk`. The first rising edge after `cs_n` falls is rising edge 1.
- R4: In minimal mode (`cfg_mode` 2'b00 or 2'b11), `res_data[9:0]` holds the bits captured on rising edges 4 through 13, most significant first.
- R5: In byte mode (`cfg_mode` 2'b01), the 16 captured bits form two bytes. `res_data` is the low 5 bits of the first byte followed by the high 5 bits of the second byte. The top 2 bits of the first byte (undefined) and the low 3 bits of the second byte (echoed bits) have no effect on the result.
- R6: In fast mode (`cfg_mode` 2'b10), `res_data[9:2]` holds the bits captured on rising edges 4 through 11, and `res_data[1:0]` is 0.
- R7: `res_err` is high together with `res_valid` exactly when the bit captured on rising edge 3 (the null bit) is 1.
- R8: `res_valid` rises (2N+2)·H clock edges after the accepting edge, at the same edge where `cs_n` returns high. While `res_ready` is 0, `res_valid`, `res_data` and `res_err` hold their values. `res_valid` falls on the edge where `res_ready` is 1.
- R9: After the result handshake, `cs_n` stays high, and `req_ready` returns exactly 2·H clock edges later.
- R10: `timing_err` is 1 exactly when 28·(`cfg_div`+1) > MAX_FRAME_CYC, or when `cfg_div`+1 < MIN_HALF. It follows `cfg_div` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Serial half-period minus one, in clock cycles |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_mode | input | 2 | Frame shape: 00 minimal, 01 byte pair, 10 fast 8-bit, 11 minimal |
| timing_err | output | 1 | Divider setting violates the frame-duration or clock-rate limit |
| req_valid | input | 1 | Request for one conversion |
| req_ready | output | 1 | Reader can accept a request |
| busy | output | 1 | A request is in progress |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| miso | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 10 | Rebuilt conversion result |
| res_err | output | 1 | Null bit was found high |

## Verification
Each result is due at a fixed distance from its trigger:
- `res_valid` appears (2N+2)·H edges after the accepting edge.
- `req_ready` returns 2·H edges after the result handshake.
- `req_ready` returns 2·2^DIV_W edges after reset release.
- `timing_err` settles in the same cycle that `cfg_div` changes.

The bench counts clock edges from each trigger and compares the count with these formulas. It samples 1 ns after each rising edge, so every read sees settled registers. A converter model in the bench shifts out the expected frame on falling serial-clock edges, including the undefined lead bits and the echoed tail. Expected words are computed from the stimulus code and the mode.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int RES_W       = 10;
  localparam int NULL_RISE   = 3;                     // rising edge that carries the null bit
  localparam int MSB_RISE    = NULL_RISE + 1;
  localparam int PULSES_MIN  = 14;
  localparam int PULSES_BYTE = 16;
  localparam int FAST_BITS   = 8;
  localparam int PULSES_FAST = NULL_RISE + FAST_BITS;
  localparam int BYTE_W      = 8;
  // the two undefined lead bits fall off the top of the shift register
  localparam int SH_W        = PULSES_BYTE - (NULL_RISE - 1);
  localparam int EDGE_W      = $clog2(2 * PULSES_BYTE + 1);

  typedef enum logic [1:0] {
    FRM_MIN  = 2'b00,
    FRM_BYTE = 2'b01,
    FRM_FAST = 2'b10,
    FRM_ALT  = 2'b11
  } frm_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_OUT,
    ST_GAP
  } rd_state_e;

  function automatic logic [EDGE_W-1:0] last_edge(frm_mode_e m);
    case (m)
      FRM_BYTE: return EDGE_W'(2 * PULSES_BYTE - 1);
      FRM_FAST: return EDGE_W'(2 * PULSES_FAST - 1);
      default:  return EDGE_W'(2 * PULSES_MIN - 1);
    endcase
  endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/adc_rd_pack.sv
module adc_rd_pack
  import adc_rd_pkg::*;
(
  input  logic [SH_W-1:0]  sh,
  input  frm_mode_e        mode,
  output logic [RES_W-1:0] data,
  output logic             null_bit
);

  // a bit captured on rising edge k of a P-pulse frame lands at sh[P-k]
  localparam int MIN_LSB  = PULSES_MIN - (MSB_RISE + RES_W - 1);
  localparam int FAST_LSB = PULSES_FAST - (MSB_RISE + FAST_BITS - 1);
  localparam int HI_KEEP  = RES_W / 2;                 // bits kept from each byte
  localparam int LO_DROP  = BYTE_W - (RES_W - HI_KEEP); // echoed tail of second byte

  logic [RES_W-1:0] min_w, byte_w, fast_w;
  logic [BYTE_W-1:0] second_byte;
  logic [HI_KEEP-1:0] first_keep;

  generate
    for (genvar i = 0; i < RES_W; i++) begin : g_min
      assign min_w[i] = sh[MIN_LSB + i];
    end
    for (genvar i = 0; i < RES_W; i++) begin : g_fast
      if (i < RES_W - FAST_BITS) begin : g_pad
        assign fast_w[i] = 1'b0;
      end else begin : g_cap
        assign fast_w[i] = sh[FAST_LSB + i - (RES_W - FAST_BITS)];
      end
    end
  endgenerate

  // byte pair: low bits of the first byte, then high bits of the second
  assign second_byte = sh[BYTE_W-1:0];
  assign first_keep  = sh[BYTE_W +: HI_KEEP];
  assign byte_w      = {first_keep, second_byte[BYTE_W-1:LO_DROP]};

  always_comb begin
    case (mode)
      FRM_BYTE: begin data = byte_w; null_bit = sh[PULSES_BYTE - NULL_RISE]; end
      FRM_FAST: begin data = fast_w; null_bit = sh[PULSES_FAST - NULL_RISE]; end
      default:  begin data = min_w;  null_bit = sh[PULSES_MIN  - NULL_RISE]; end
    endcase
  end

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic [1:0]       cfg_mode,
  input  logic             req_valid,
  input  logic             res_ready,
  input  logic             miso,
  input  logic [RES_W-1:0] pack_data,
  input  logic             pack_null,
  output logic             run,
  output logic [DIV_W-1:0] div_q,
  output frm_mode_e        mode_q,
  output logic [SH_W-1:0]  sh,
  output logic             cs_n,
  output logic             sclk,
  output logic             req_ready,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_err
);

  rd_state_e         st;
  logic              sclk_q;
  logic              gap_half;
  logic [EDGE_W-1:0] edge_cnt;

  assign req_ready = (st == ST_IDLE);
  assign run       = (st == ST_SETUP) || (st == ST_SHIFT) || (st == ST_HOLD) || (st == ST_GAP);
  assign sclk      = (st == ST_IDLE) ? cfg_cpol : sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_GAP;
      cs_n      <= 1'b1;
      sclk_q    <= 1'b0;
      gap_half  <= 1'b0;
      edge_cnt  <= '0;
      div_q     <= '1;
      mode_q    <= FRM_MIN;
      sh        <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          sclk_q <= cfg_cpol;
          if (req_valid) begin
            div_q    <= cfg_div;
            mode_q   <= frm_mode_e'(cfg_mode);
            cs_n     <= 1'b0;
            edge_cnt <= '0;
            sh       <= '0;
            st       <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) st <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          sclk_q   <= ~sclk_q;
          if (!sclk_q) sh <= {sh[SH_W-2:0], miso};
          edge_cnt <= edge_cnt + 1'b1;
          if (edge_cnt == last_edge(mode_q)) st <= ST_HOLD;
        end
        ST_HOLD: if (tick) begin
          cs_n      <= 1'b1;
          res_valid <= 1'b1;
          res_data  <= pack_data;
          res_err   <= pack_null;
          st        <= ST_OUT;
        end
        ST_OUT: if (res_ready) begin
          res_valid <= 1'b0;
          gap_half  <= 1'b0;
          st        <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_half) st <= ST_IDLE;
          gap_half <= 1'b1;
        end
        default: st <= ST_GAP;
      endcase
    end
  end

endmodule

// File: rtl/adc_spi_reader.sv
module adc_spi_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_W         = 16,
  parameter int MIN_HALF      = 45,
  parameter int MAX_FRAME_CYC = 175000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic [1:0]       cfg_mode,
  output logic             timing_err,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             busy,
  output logic             sclk,
  output logic             cs_n,
  input  logic             miso,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic             res_err
);

  localparam int FW = DIV_W + 6;

  logic             run, tick, pack_null;
  logic [DIV_W-1:0] div_q;
  frm_mode_e        mode_q;
  logic [SH_W-1:0]  sh;
  logic [RES_W-1:0] pack_data;
  logic [FW-1:0]    half_cyc, frame_cyc;

  assign half_cyc   = FW'(cfg_div) + FW'(1);
  assign frame_cyc  = FW'(2 * PULSES_MIN) * half_cyc;
  assign timing_err = (frame_cyc > FW'(MAX_FRAME_CYC)) || (half_cyc < FW'(MIN_HALF));
  assign busy       = ~req_ready;

  adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  adc_rd_pack u_pack (
    .sh(sh), .mode(mode_q), .data(pack_data), .null_bit(pack_null)
  );

  adc_rd_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_mode(cfg_mode),
    .req_valid(req_valid), .res_ready(res_ready), .miso(miso),
    .pack_data(pack_data), .pack_null(pack_null),
    .run(run), .div_q(div_q), .mode_q(mode_q), .sh(sh),
    .cs_n(cs_n), .sclk(sclk), .req_ready(req_ready),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
  );

endmodule

// File: rtl/adc_spi_reader_chk.sv
module adc_spi_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       req_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic [9:0] res_data,
  input logic       res_err
);

  logic [7:0] hi_cnt;
  logic [6:0] edges;
  logic       sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      edges  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
      if (cs_n) edges <= '0;
      else if (sclk != sclk_d && edges != 7'h7F) edges <= edges + 1'b1;
    end
  end

  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);  // R2

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && !req_ready && !$past(req_ready)) |-> $stable(sclk));  // R3

  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> edges <= 7'd32);  // R3

  AST_RESULT_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cs_n);  // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_err)));  // R8

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= 8'd2);  // R9

endmodule

bind adc_spi_reader adc_spi_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_err(res_err)
);

// File: tb/sim_adc_spi_reader.sv
module sim_adc_spi_reader;

  localparam int DW   = 4;
  localparam int MINH = 2;
  localparam int MAXF = 224;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] cfg_div = 4'd3;
  logic          cfg_cpol = 1'b0;
  logic [1:0]    cfg_mode = 2'b00;
  logic          req_valid = 1'b0;
  logic          res_ready = 1'b0;
  logic          miso = 1'b1;
  logic          timing_err, req_ready, busy, sclk, cs_n, res_valid, res_err;
  logic [9:0]    res_data;

  always #2 clk = ~clk;

  adc_spi_reader #(.DIV_W(DW), .MIN_HALF(MINH), .MAX_FRAME_CYC(MAXF)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_mode(cfg_mode),
    .timing_err(timing_err), .req_valid(req_valid), .req_ready(req_ready), .busy(busy),
    .sclk(sclk), .cs_n(cs_n), .miso(miso), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_err(res_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // converter model: data changes on falling edges that follow a rising edge
  logic [9:0] mdl_code = '0;
  logic       mdl_null = 1'b0;
  int         rises = 0;
  int         falls = 0;
  logic       sprev = 1'b0;

  function automatic logic mbit(input int f);
    if (f < 2)   return 1'b1;               // undefined lead bits
    if (f == 2)  return mdl_null;
    if (f <= 12) return mdl_code[12 - f];   // B9..B0
    if (f <= 15) return mdl_code[f - 12];   // echoed B1..B3
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (cs_n) begin
      rises = 0;
      falls = 0;
      miso  = 1'b1;
    end else begin
      if (sclk && !sprev) rises = rises + 1;
      if (!sclk && sprev && rises > 0) begin
        falls = falls + 1;
        miso  = mbit(falls);
      end
    end
    sprev = sclk;
  end

  task automatic do_frame(input int mode, input int cpol, input int div,
                          input logic [9:0] code, input bit inj, input int bp);
    int np, h, lat, rs;
    logic sp;
    logic [9:0] expd, held;
    string dtag;
    np   = (mode == 1) ? 16 : (mode == 2) ? 11 : 14;
    h    = div + 1;
    expd = (mode == 2) ? {code[9:2], 2'b00} : code;
    dtag = (mode == 1) ? "R5 byte-pair word" : (mode == 2) ? "R6 fast word" : "R4 minimal word";
    @(negedge clk);
    cfg_mode = mode[1:0]; cfg_cpol = cpol[0]; cfg_div = div[DW-1:0];
    mdl_code = code; mdl_null = inj; req_valid = 1'b1;
    #1;
    chk(req_ready && cs_n, "R2 ready and cs high when idle", {req_ready, cs_n}, 3);
    chk(sclk == cpol[0], "R3 idle sclk level", sclk, cpol);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(busy && !req_ready && !cs_n, "R2 busy after accept", {busy, req_ready, cs_n}, 4);
    lat = 0; rs = 0; sp = sclk;
    while (!res_valid && lat < 2000) begin
      @(posedge clk); #1;
      lat++;
      if (sclk && !sp) rs++;
      sp = sclk;
    end
    chk(lat == (2 * np + 2) * h, "R8 result latency", lat, (2 * np + 2) * h);
    chk(rs == np, "R3 rising pulse count", rs, np);
    chk(sclk == cpol[0] && cs_n, "R3 sclk back at idle, cs high", {sclk, cs_n}, {cpol[0], 1'b1});
    chk(res_data == expd, dtag, res_data, expd);
    chk(res_err == inj, "R7 null-bit error flag", res_err, inj);
    held = res_data;
    repeat (bp) begin
      @(posedge clk); #1;
      chk(res_valid && res_data == held, "R8 hold under back-pressure", res_data, held);
    end
    res_ready = 1'b1;
    @(posedge clk); #1;
    res_ready = 1'b0;
    chk(!res_valid, "R8 valid drops on handshake", res_valid, 0);
    lat = 0;
    while (!req_ready && lat < 2000) begin
      if (!cs_n) chk(1'b0, "R9 cs low during gap", cs_n, 1);
      @(posedge clk); #1;
      lat++;
    end
    chk(lat == 2 * h, "R9 gap length", lat, 2 * h);
  endtask

  initial begin
    int lat;
    logic [9:0] codes [6];
    codes[0] = 10'h000; codes[1] = 10'h3FF; codes[2] = 10'h2AA;
    codes[3] = 10'h155; codes[4] = 10'h001; codes[5] = 10'h200;

    repeat (4) @(posedge clk);
    #1;
    chk(cs_n && !res_valid && !req_ready, "R1 state during reset", {cs_n, res_valid, req_ready}, 4);
    @(negedge clk);
    rst_n = 1'b1;
    lat = 0;
    while (!req_ready && lat < 1000) begin
      @(posedge clk); #1;
      lat++;
      if (!cs_n) chk(1'b0, "R1 cs low after reset", cs_n, 1);
    end
    chk(lat == 2 * (1 << DW), "R1 ready after reset", lat, 2 * (1 << DW));

    for (int d = 0; d < (1 << DW); d++) begin
      bit e;
      @(negedge clk);
      cfg_div = d[DW-1:0];
      #1;
      e = (28 * (d + 1) > MAXF) || (d + 1 < MINH);
      chk(timing_err == e, "R10 timing flag", timing_err, e);
    end

    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int di = 0; di < 3; di++)
          for (int k = 0; k < 6; k++)
            do_frame(m, c, (di == 2) ? 3 : di, codes[k], (k == 2) || (k == 5 && c == 1), di);

    for (int v = 0; v < 1024; v++) do_frame(1, v & 1, 0, v[9:0], 1'b0, 0);
    for (int v = 0; v < 1024; v++) do_frame(2, (v >> 1) & 1, 0, v[9:0], v[3], 0);
    for (int v = 0; v < 1024; v += 7) do_frame(0, v & 1, 0, v[9:0], 1'b0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule